// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Memory

This block is a 16-entry memory of 8-bit words protected by an extended Hamming code. Each write encodes the data into a 13-bit code word: four check bits, one overall parity bit and the eight data bits. The whole code word is stored. On a read, a 4-bit syndrome is computed from the stored word. A nonzero syndrome gives the position of a failing bit. The overall parity tells a single error from a double error. A single error is repaired on the way out. An error that cannot be corrected is flagged, and the data is returned as it was stored.

A test port flips any chosen set of stored bits at one address. Verification uses it to inject faults. The read result and both flags are registered. The stored word is never rewritten with corrected data.

Top module: `secded_mem`

## Requirements
- R1: After reset, rdata, single_err and double_err are 0. Every entry holds the code word for data 0, so it reads back as 0 with both flags low.
- R2: Data bit wdata[i] is data bit D(i+1). Stored word bit k (k = 1..12) holds code position k, in the order C1, C2, D1, C4, D2, D3, D4, C8, D5, D6, D7, D8. Bit 0 is the overall parity bit, which makes the parity of all 13 bits even. The check bits are C1 = D1^D2^D4^D5^D7, C2 = D1^D3^D4^D6^D7, C4 = D2^D3^D4^D8 and C8 = D5^D6^D7^D8.
- R3: rdata, single_err and double_err are updated at the clock edge that samples re high, and are valid from that edge on. For an error-free word, rdata equals the written data and both flags are low.
- R4: If exactly one of stored bits 1..12 is inverted, the read returns the corrected data with single_err=1 and double_err=0.
- R5: If only stored bit 0 is inverted, the read returns the data unchanged with single_err=1 and double_err=0.
- R6: If two stored bits are inverted, the read returns double_err=1 and single_err=0. rdata is the uncorrected content of bits 3,5,6,7,9,10,11,12.
- R7: A syndrome of 13, 14 or 15 with failed overall parity gives double_err=1 and single_err=0. The uncorrected data is returned.
- R8: While re is low, rdata and both flags hold their values.
- R9: With flip_en high, the stored word at flip_addr is XORed with flip_mask, where mask bit k targets stored bit k. A write to the same address in the same cycle takes priority, and the flip is dropped.
- R10: A read and a write to the same address in the same cycle return the contents from before the write.
- R11: single_err and double_err are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| we | input | 1 | Write enable |
| addr | input | 4 | Shared read/write address |
| wdata | input | 8 | Write data |
| re | input | 1 | Read enable |
| flip_en | input | 1 | Test port: apply flip_mask |
| flip_addr | input | 4 | Test port: target address |
| flip_mask | input | 13 | Test port: stored bits to invert |
| rdata | output | 8 | Registered read data |
| single_err | output | 1 | Registered: corrected or parity-bit error |
| double_err | output | 1 | Registered: uncorrectable error |

## Verification
Writes and flips change the stored word at the rising edge that samples them. A read's data and flags appear at the rising edge that samples re and stay put until the next read. The bench drives inputs at the falling edge. Its behavioural model updates its expected outputs and its memory at the rising edge, and the outputs are compared at the following falling edge on every cycle, idle ones included, so that a result arriving one cycle early or late is caught.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 8;
  localparam int SYN_W  = 4;
  localparam int CW_W   = 13;

  // Stored word: bit 0 overall parity, bits 1..12 code positions 1..12.
  function automatic logic [CW_W-1:0] secded_encode(input logic [DATA_W-1:0] d);
    logic [CW_W-1:0] w;
    w = '0;
    w[3]  = d[0];
    w[5]  = d[1];
    w[6]  = d[2];
    w[7]  = d[3];
    w[9]  = d[4];
    w[10] = d[5];
    w[11] = d[6];
    w[12] = d[7];
    w[1]  = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    w[2]  = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    w[4]  = d[1] ^ d[2] ^ d[3] ^ d[7];
    w[8]  = d[4] ^ d[5] ^ d[6] ^ d[7];
    w[0]  = ^w[CW_W-1:1];
    return w;
  endfunction

  function automatic logic [SYN_W-1:0] secded_syndrome(input logic [CW_W-1:0] w);
    logic [SYN_W-1:0] s;
    s[0] = w[1] ^ w[3] ^ w[5] ^ w[7] ^ w[9]  ^ w[11];
    s[1] = w[2] ^ w[3] ^ w[6] ^ w[7] ^ w[10] ^ w[11];
    s[2] = w[4] ^ w[5] ^ w[6] ^ w[7] ^ w[12];
    s[3] = w[8] ^ w[9] ^ w[10] ^ w[11] ^ w[12];
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] secded_data(input logic [CW_W-1:0] w);
    return {w[12], w[11], w[10], w[9], w[7], w[6], w[5], w[3]};
  endfunction
endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_in,
  output logic [CW_W-1:0]   code_out
);
  assign code_out = secded_encode(data_in);
endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
  import secded_pkg::*;
(
  input  logic [CW_W-1:0]   code_in,
  output logic [DATA_W-1:0] data_out,
  output logic [SYN_W-1:0]  syndrome,
  output logic              parity_fail,
  output logic              single_hit,
  output logic              double_hit
);
  localparam int LAST_POS = CW_W - 1;

  logic [CW_W-1:0] fix_mask;
  logic            pos_valid;

  assign syndrome    = secded_syndrome(code_in);
  assign parity_fail = ^code_in;
  assign pos_valid   = (int'(syndrome) <= LAST_POS);

  always_comb begin
    single_hit = 1'b0;
    double_hit = 1'b0;
    fix_mask   = '0;
    if (syndrome == '0) begin
      single_hit = parity_fail;
    end else if (parity_fail && pos_valid) begin
      single_hit = 1'b1;
      fix_mask   = CW_W'(1) << syndrome;
    end else begin
      double_hit = 1'b1;
    end
  end

  assign data_out = secded_data(code_in ^ fix_mask);
endmodule

// File: rtl/secded_store.sv
module secded_store
  import secded_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [CW_W-1:0] wr_word,
  input  logic            flip_en,
  input  logic [AW-1:0]   flip_addr,
  input  logic [CW_W-1:0] flip_mask,
  input  logic [AW-1:0]   rd_addr,
  output logic [CW_W-1:0] rd_word
);
  logic [CW_W-1:0] mem [DEPTH];
  logic            flip_blocked;

  assign flip_blocked = wr_en && (wr_addr == flip_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (flip_en && !flip_blocked) mem[flip_addr] <= mem[flip_addr] ^ flip_mask;
      if (wr_en) mem[wr_addr] <= wr_word;
    end
  end

  assign rd_word = mem[rd_addr];

  // R9: a write to the flipped address wins over the flip
  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && flip_en && flip_addr == wr_addr) |=> mem[$past(wr_addr)] == $past(wr_word));
endmodule

// File: rtl/secded_mem.sv
module secded_mem
  import secded_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic              flip_en,
  input  logic [AW-1:0]     flip_addr,
  input  logic [CW_W-1:0]   flip_mask,
  output logic [DATA_W-1:0] rdata,
  output logic              single_err,
  output logic              double_err
);
  logic [CW_W-1:0]   enc_word;
  logic [CW_W-1:0]   raw_cw;
  logic [DATA_W-1:0] dec_data;
  logic [SYN_W-1:0]  dec_syn;
  logic              dec_pfail;
  logic              dec_single;
  logic              dec_double;

  secded_encoder u_enc (
    .data_in (wdata),
    .code_out(enc_word)
  );

  secded_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (we),
    .wr_addr  (addr),
    .wr_word  (enc_word),
    .flip_en  (flip_en),
    .flip_addr(flip_addr),
    .flip_mask(flip_mask),
    .rd_addr  (addr),
    .rd_word  (raw_cw)
  );

  secded_decoder u_dec (
    .code_in    (raw_cw),
    .data_out   (dec_data),
    .syndrome   (dec_syn),
    .parity_fail(dec_pfail),
    .single_hit (dec_single),
    .double_hit (dec_double)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata      <= '0;
      single_err <= 1'b0;
      double_err <= 1'b0;
    end else if (re) begin
      rdata      <= dec_data;
      single_err <= dec_single;
      double_err <= dec_double;
    end
  end

  // R8: outputs hold while no read is sampled
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> ($stable(rdata) && $stable(single_err) && $stable(double_err)));

  // R11: flags are exclusive
  assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    single_err |-> !double_err);

  // R3: a valid code word reads back clean
  assert_clean_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (re && raw_cw == secded_encode(secded_data(raw_cw)))
    |=> (!single_err && !double_err && rdata == secded_data($past(raw_cw))));

  // R4: a word one bit away from the code word of the returned data is a single error
  assert_single_fix_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (re && $countones(raw_cw ^ secded_encode(dec_data)) == 1)
    |=> (single_err && !double_err));
endmodule

// File: tb/secded_mem_test.sv
module secded_mem_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0, flip_en = 1'b0;
  logic [3:0]  addr = '0, flip_addr = '0;
  logic [7:0]  wdata = '0;
  logic [12:0] flip_mask = '0;
  logic [7:0]  rdata;
  logic        single_err, double_err;

  int errors = 0;
  int checks = 0;

  logic [12:0] model [16];
  logic [7:0]  exp_data = '0;
  logic        exp_single = 1'b0, exp_double = 1'b0;

  always #4 clk = ~clk;

  secded_mem uut (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .re(re),
    .flip_en(flip_en), .flip_addr(flip_addr), .flip_mask(flip_mask),
    .rdata(rdata), .single_err(single_err), .double_err(double_err)
  );

  function automatic bit is_pow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [12:0] ref_encode(logic [7:0] d);
    logic [12:0] w = '0;
    int j = 0;
    int syn = 0;
    for (int p = 1; p <= 12; p++) if (!is_pow2(p)) begin w[p] = d[j]; j++; end
    for (int p = 1; p <= 12; p++) if (w[p]) syn = syn ^ p;
    for (int b = 0; b < 4; b++) w[1 << b] = syn[b];
    w[0] = ^w[12:1];
    return w;
  endfunction

  function automatic logic [7:0] ref_extract(logic [12:0] w);
    logic [7:0] d = '0;
    int j = 0;
    for (int p = 1; p <= 12; p++) if (!is_pow2(p)) begin d[j] = w[p]; j++; end
    return d;
  endfunction

  task automatic ref_read(logic [12:0] w);
    int syn = 0;
    logic par = ^w;
    for (int p = 1; p <= 12; p++) if (w[p]) syn = syn ^ p;
    exp_single = 1'b0;
    exp_double = 1'b0;
    exp_data   = ref_extract(w);
    if (syn == 0) exp_single = par;
    else if (par && syn <= 12) begin
      w[syn] = ~w[syn];
      exp_data   = ref_extract(w);
      exp_single = 1'b1;
    end else exp_double = 1'b1;
  endtask

  task automatic check(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic compare(string tag);
    check(rdata == exp_data, tag, "rdata", int'(rdata), int'(exp_data));
    check(single_err == exp_single, tag, "single_err", int'(single_err), int'(exp_single));
    check(double_err == exp_double, tag, "double_err", int'(double_err), int'(exp_double));
    check(!(single_err && double_err), "R11", "flag overlap", int'({single_err, double_err}), 2);
  endtask

  // Called at a falling edge; returns at the next falling edge after comparing.
  task automatic cyc(bit w, bit r, logic [3:0] a, logic [7:0] d,
                     bit f, logic [3:0] fa, logic [12:0] fm, string tag);
    we = w; re = r; addr = a; wdata = d; flip_en = f; flip_addr = fa; flip_mask = fm;
    @(posedge clk);
    if (r) ref_read(model[a]);
    if (f && !(w && fa == a)) model[fa] = model[fa] ^ fm;
    if (w) model[a] = ref_encode(d);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d, string tag);
    cyc(1, 0, a, d, 0, 0, 0, tag);
  endtask
  task automatic rd(logic [3:0] a, string tag);
    cyc(0, 1, a, 0, 0, 0, 0, tag);
  endtask
  task automatic flip(logic [3:0] fa, logic [12:0] fm, string tag);
    cyc(0, 0, 0, 0, 1, fa, fm, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) rd(4'(i), "R1");

    // R2/R3: write and read back several patterns
    wr(4'd0, 8'h39, "R2");
    wr(4'd1, 8'hFF, "R2");
    wr(4'd2, 8'hA5, "R2");
    wr(4'd15, 8'h01, "R2");
    rd(4'd0, "R3");
    rd(4'd1, "R3");
    rd(4'd2, "R2");
    rd(4'd15, "R3");
    for (int v = 0; v < 256; v += 17) begin
      wr(4'd7, 8'(v), "R2");
      rd(4'd7, "R2");
    end

    // R4 / R5: every single bit position
    for (int k = 0; k <= 12; k++) begin
      wr(4'd3, 8'h39, "R4");
      flip(4'd3, 13'(1) << k, "R4");
      rd(4'd3, (k == 0) ? "R5" : "R4");
    end

    // R6: bit pairs
    for (int k = 0; k < 12; k++) begin
      wr(4'd4, 8'hC6, "R6");
      flip(4'd4, (13'(1) << k) | (13'(1) << (k + 1)), "R6");
      rd(4'd4, "R6");
    end

    // R7: syndrome 13, 14, 15 with odd parity
    wr(4'd5, 8'h5A, "R7");
    flip(4'd5, (13'(1) << 1) | (13'(1) << 4) | (13'(1) << 8), "R7");
    rd(4'd5, "R7");
    wr(4'd5, 8'h5A, "R7");
    flip(4'd5, (13'(1) << 2) | (13'(1) << 4) | (13'(1) << 8), "R7");
    rd(4'd5, "R7");
    wr(4'd5, 8'h5A, "R7");
    flip(4'd5, (13'(1) << 3) | (13'(1) << 4) | (13'(1) << 8), "R7");
    rd(4'd5, "R7");

    // R8: idle cycles with writes and flips leave outputs alone
    rd(4'd5, "R8");
    for (int i = 0; i < 4; i++) cyc(1, 0, 4'd6, 8'(i), 1, 4'd5, 13'h1FFF, "R8");

    // R9: write wins on same address; flip lands on a different one
    wr(4'd8, 8'h12, "R9");
    cyc(1, 0, 4'd8, 8'h34, 1, 4'd8, 13'h0040, "R9");
    rd(4'd8, "R9");
    wr(4'd9, 8'h77, "R9");
    cyc(1, 0, 4'd10, 8'h88, 1, 4'd9, 13'h0400, "R9");
    rd(4'd9, "R9");
    rd(4'd10, "R9");

    // R10: read during write sees old contents
    wr(4'd11, 8'hAA, "R10");
    cyc(1, 1, 4'd11, 8'h55, 0, 0, 0, "R10");
    rd(4'd11, "R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule